// File: doc/BRIEF.md
# Instruction Sequencing Control Unit

This block is the control state machine of a small 16-bit load/store processor. It takes every instruction through a fixed series of steps: fetch, decode, operand read, execute, write-back and program-counter update. In each state it drives one packed 29-bit control word. The word holds the write enables and the multiplexer selects for a datapath outside the block. That datapath contains the memory, the register file, the ALU and the holding buffers.

The block reads two inputs from the datapath. One is the 8-bit opcode held in the instruction buffer, which must stay stable from decode until the instruction returns to fetch. The other is the low bit of the first register read buffer. Conditional jumps pass that bit, or its inverse, straight to the PC-mux select field. The program counter advances by four: the ALU adds PC and four in one state, and the next state writes the result back. The current state is also driven out for debug.

States and their codes: FETCH (0), DECODE (1), READ_BOTH (2), READ_ONE (3), EXEC_RR (4), EXEC_IMM (5), WRITE_BACK (6), COPY_REG (7), COPY_IMM (8), JUMP (9), JUMP_TRUE (10), JUMP_FALSE (11), PC_INC (12), PC_STORE (13).

Transitions:
- FETCH goes to DECODE.
- DECODE goes to READ_BOTH for the register-register ALU ops.
- DECODE goes to READ_ONE for ADDI, SUBI, COPY, TJMP and FJMP.
- DECODE goes to COPY_IMM for COPI and to JUMP for JUMP.
- DECODE goes to PC_INC for any other opcode.
- READ_BOTH goes to EXEC_RR.
- READ_ONE goes to EXEC_IMM, COPY_REG, JUMP_TRUE or JUMP_FALSE, depending on the opcode.
- Both execute states go to WRITE_BACK, and WRITE_BACK goes to PC_INC.
- COPY_REG and COPY_IMM go to PC_INC.
- JUMP goes to FETCH.
- JUMP_TRUE and JUMP_FALSE go to FETCH when the jump is taken and to PC_INC when it is not.
- PC_INC goes to PC_STORE, and PC_STORE goes to FETCH.

Top module: `proc_ctrl_fsm`

## Requirements
- R1: While reset (synchronous, active high) is asserted, the control word is all zeros. After the first clock edge in reset the state output reads FETCH (code 0).
- R2: In FETCH the control word is 0x0800000 (bit 23 only, instruction buffer enable), and the next state is always DECODE. In DECODE the control word is 0x0000000.
- R3: The register-register opcodes are ADD 0x00, SUB 0x01, AND 0x03, OR 0x04, XOR 0x05, SRR 0x06, SRL 0x07, SLT 0x08 and SEQ 0x09. Each runs FETCH, DECODE, READ_BOTH, EXEC_RR, WRITE_BACK, PC_INC, PC_STORE and back to FETCH. READ_BOTH drives 0x0300000 (bits 21 and 20).
- R4: EXEC_RR drives 0x2000000 (bit 25) OR the ALU code in bits 3:0. The codes are ADD 0, SUB 1, AND 3, OR 4, XOR 5, SRR 6, SRL 7, SLT 8 and SEQ 9.
- R5: WRITE_BACK drives 0x8001000 (bit 27, write-data select 01 in bits 13:12). PC_INC drives 0x2000A00 (bit 25, ALU A select 10 in bits 11:10, ALU B select 10 in bits 9:8). PC_STORE drives 0x1000000 (bit 24, PC-mux select bit 19 low).
- R6: ADDI 0xFF and SUBI 0xFE run FETCH, DECODE, READ_ONE, EXEC_IMM, WRITE_BACK, PC_INC, PC_STORE. READ_ONE drives 0x0210000 (bits 21 and 16). EXEC_IMM drives 0x2010100 OR the ALU code (0 for ADDI, 1 for SUBI).
- R7: COPY 0x0A runs FETCH, DECODE, READ_ONE, COPY_REG, PC_INC, PC_STORE, and COPY_REG drives 0x8002000 (select 10). COPI 0xFD runs FETCH, DECODE, COPY_IMM, PC_INC, PC_STORE, and COPY_IMM drives 0x8003000 (select 11).
- R8: JUMP 0xE0 runs FETCH, DECODE, JUMP, FETCH. JUMP drives 0x1080000 (bits 24 and 19).
- R9: TJMP 0xFC runs FETCH, DECODE, READ_ONE, JUMP_TRUE. JUMP_TRUE drives 0x1000000 with bit 19 equal to the register low-bit input. It then goes to FETCH when that bit is 1 and to PC_INC, PC_STORE when it is 0.
- R10: FJMP 0xFB runs FETCH, DECODE, READ_ONE, JUMP_FALSE. JUMP_FALSE drives 0x1000000 with bit 19 equal to the inverse of the register low bit. It then goes to FETCH when that bit is 0 and to PC_INC, PC_STORE when it is 1.
- R11: Any other opcode, for example 0x02, 0x0B or 0x80, runs FETCH, DECODE, PC_INC, PC_STORE. No such instruction ever asserts bit 28 or bit 27.
- R12: Reset asserted in the middle of an instruction clears the control word at once. The machine restarts from FETCH once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 8 | Opcode from the instruction buffer |
| rbuf0_lsb_i | input | 1 | Low bit of the first register read buffer |
| ctl_word_o | output | 29 | Packed control word |
| state_o | output | 4 | Current state code (debug) |

## Verification
The bench targets the conditional jumps with both values of the register bit. A design with the taken and not-taken paths swapped, or with the FJMP bit not inverted, would write the wrong PC and go to the wrong next state. It also runs the opcodes that sit between the defined ones (0x02, 0x0B) and one far outside them (0x80). A decoder that matched too loosely would start a register write for these. The remaining targets are the gap in the ALU codes, where AND is 3 and not 2, and the field positions of the immediate-select and PC+4 selects. A reset in the middle of an instruction checks that the word clears in the same cycle and does not leave an enable asserted.

// File: rtl/pctl_pkg.sv
`timescale 1ns/1ps
package pctl_pkg;

    localparam int CW_W  = 29;
    localparam int OP_W  = 8;
    localparam int ST_W  = 4;
    localparam int ALU_W = 4;
    localparam int SEL_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH      = 4'd0,
        ST_DECODE     = 4'd1,
        ST_READ_BOTH  = 4'd2,
        ST_READ_ONE   = 4'd3,
        ST_EXEC_RR    = 4'd4,
        ST_EXEC_IMM   = 4'd5,
        ST_WRITE_BACK = 4'd6,
        ST_COPY_REG   = 4'd7,
        ST_COPY_IMM   = 4'd8,
        ST_JUMP       = 4'd9,
        ST_JUMP_TRUE  = 4'd10,
        ST_JUMP_FALSE = 4'd11,
        ST_PC_INC     = 4'd12,
        ST_PC_STORE   = 4'd13
    } state_t;

    typedef enum logic [2:0] {
        CL_ALU_RR   = 3'd0,
        CL_ALU_IMM  = 3'd1,
        CL_COPY     = 3'd2,
        CL_COPY_IMM = 3'd3,
        CL_JUMP     = 3'd4,
        CL_JUMP_T   = 3'd5,
        CL_JUMP_F   = 3'd6,
        CL_NOP      = 3'd7
    } opclass_t;

    // Packed control word, most significant field first (bit 28 down to bit 0).
    typedef struct packed {
        logic              mem_we;
        logic              reg_we;
        logic              aluo_we;
        logic              alubuf_en;
        logic              pc_we;
        logic              ibuf_en;
        logic              mbuf_en;
        logic              rbuf0_en;
        logic              rbuf1_en;
        logic              pc_sel;
        logic              maddr_sel;
        logic              mwr_sel;
        logic              ra0_sel;
        logic              ra1_sel;
        logic              raw_sel;
        logic [SEL_W-1:0]  wd_sel;
        logic [SEL_W-1:0]  a_sel;
        logic [SEL_W-1:0]  b_sel;
        logic [3:0]        flag_ofs;
        logic [ALU_W-1:0]  alu_op;
    } ctl_word_t;

    // Opcodes
    localparam logic [OP_W-1:0] OPC_ADD  = 8'h00;
    localparam logic [OP_W-1:0] OPC_SUB  = 8'h01;
    localparam logic [OP_W-1:0] OPC_AND  = 8'h03;
    localparam logic [OP_W-1:0] OPC_OR   = 8'h04;
    localparam logic [OP_W-1:0] OPC_XOR  = 8'h05;
    localparam logic [OP_W-1:0] OPC_SRR  = 8'h06;
    localparam logic [OP_W-1:0] OPC_SRL  = 8'h07;
    localparam logic [OP_W-1:0] OPC_SLT  = 8'h08;
    localparam logic [OP_W-1:0] OPC_SEQ  = 8'h09;
    localparam logic [OP_W-1:0] OPC_COPY = 8'h0A;
    localparam logic [OP_W-1:0] OPC_ADDI = 8'hFF;
    localparam logic [OP_W-1:0] OPC_SUBI = 8'hFE;
    localparam logic [OP_W-1:0] OPC_COPI = 8'hFD;
    localparam logic [OP_W-1:0] OPC_JUMP = 8'hE0;
    localparam logic [OP_W-1:0] OPC_TJMP = 8'hFC;
    localparam logic [OP_W-1:0] OPC_FJMP = 8'hFB;

    // ALU operation codes
    localparam logic [ALU_W-1:0] ALU_ADD = 4'h0;
    localparam logic [ALU_W-1:0] ALU_SUB = 4'h1;
    localparam logic [ALU_W-1:0] ALU_AND = 4'h3;
    localparam logic [ALU_W-1:0] ALU_OR  = 4'h4;
    localparam logic [ALU_W-1:0] ALU_XOR = 4'h5;
    localparam logic [ALU_W-1:0] ALU_SRR = 4'h6;
    localparam logic [ALU_W-1:0] ALU_SRL = 4'h7;
    localparam logic [ALU_W-1:0] ALU_SLT = 4'h8;
    localparam logic [ALU_W-1:0] ALU_SEQ = 4'h9;

    // Multiplexer select encodings
    localparam logic [SEL_W-1:0] WD_ALU   = 2'b01;
    localparam logic [SEL_W-1:0] WD_REG   = 2'b10;
    localparam logic [SEL_W-1:0] WD_IMM   = 2'b11;
    localparam logic [SEL_W-1:0] B_IMM    = 2'b01;
    localparam logic [SEL_W-1:0] A_PC     = 2'b10;
    localparam logic [SEL_W-1:0] B_FOUR   = 2'b10;

endpackage

// File: rtl/pctl_opdec.sv
`timescale 1ns/1ps
module pctl_opdec
    import pctl_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic [OPW-1:0]   opcode,
    output opclass_t         cls,
    output logic [ALU_W-1:0] alu_code
);

    always_comb begin
        cls      = CL_NOP;
        alu_code = ALU_ADD;
        unique case (opcode)
            OPC_ADD:  begin cls = CL_ALU_RR;  alu_code = ALU_ADD; end
            OPC_SUB:  begin cls = CL_ALU_RR;  alu_code = ALU_SUB; end
            OPC_AND:  begin cls = CL_ALU_RR;  alu_code = ALU_AND; end
            OPC_OR:   begin cls = CL_ALU_RR;  alu_code = ALU_OR;  end
            OPC_XOR:  begin cls = CL_ALU_RR;  alu_code = ALU_XOR; end
            OPC_SRR:  begin cls = CL_ALU_RR;  alu_code = ALU_SRR; end
            OPC_SRL:  begin cls = CL_ALU_RR;  alu_code = ALU_SRL; end
            OPC_SLT:  begin cls = CL_ALU_RR;  alu_code = ALU_SLT; end
            OPC_SEQ:  begin cls = CL_ALU_RR;  alu_code = ALU_SEQ; end
            OPC_COPY: cls = CL_COPY;
            OPC_ADDI: begin cls = CL_ALU_IMM; alu_code = ALU_ADD; end
            OPC_SUBI: begin cls = CL_ALU_IMM; alu_code = ALU_SUB; end
            OPC_COPI: cls = CL_COPY_IMM;
            OPC_JUMP: cls = CL_JUMP;
            OPC_TJMP: cls = CL_JUMP_T;
            OPC_FJMP: cls = CL_JUMP_F;
            default:  cls = CL_NOP;
        endcase
    end

endmodule

// File: rtl/pctl_next_state.sv
`timescale 1ns/1ps
module pctl_next_state
    import pctl_pkg::*;
(
    input  state_t   cur,
    input  opclass_t cls,
    input  logic     rbit,
    output state_t   nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_ALU_RR:   nxt = ST_READ_BOTH;
                    CL_ALU_IMM,
                    CL_COPY,
                    CL_JUMP_T,
                    CL_JUMP_F:   nxt = ST_READ_ONE;
                    CL_COPY_IMM: nxt = ST_COPY_IMM;
                    CL_JUMP:     nxt = ST_JUMP;
                    default:     nxt = ST_PC_INC;
                endcase
            end
            ST_READ_BOTH: nxt = ST_EXEC_RR;
            ST_READ_ONE: begin
                unique case (cls)
                    CL_ALU_IMM: nxt = ST_EXEC_IMM;
                    CL_COPY:    nxt = ST_COPY_REG;
                    CL_JUMP_T:  nxt = ST_JUMP_TRUE;
                    CL_JUMP_F:  nxt = ST_JUMP_FALSE;
                    default:    nxt = ST_PC_INC;
                endcase
            end
            ST_EXEC_RR,
            ST_EXEC_IMM:   nxt = ST_WRITE_BACK;
            ST_WRITE_BACK,
            ST_COPY_REG,
            ST_COPY_IMM:   nxt = ST_PC_INC;
            ST_JUMP:       nxt = ST_FETCH;
            ST_JUMP_TRUE:  nxt = rbit  ? ST_FETCH : ST_PC_INC;
            ST_JUMP_FALSE: nxt = !rbit ? ST_FETCH : ST_PC_INC;
            ST_PC_INC:     nxt = ST_PC_STORE;
            ST_PC_STORE:   nxt = ST_FETCH;
            default:       nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/pctl_word_gen.sv
`timescale 1ns/1ps
module pctl_word_gen
    import pctl_pkg::*;
(
    input  state_t           cur,
    input  logic [ALU_W-1:0] alu_code,
    input  logic             rbit,
    input  logic             quiet,
    output ctl_word_t        word
);

    always_comb begin
        word = '0;
        if (!quiet) begin
            unique case (cur)
                ST_FETCH:  word.ibuf_en = 1'b1;
                ST_DECODE: word = '0;
                ST_READ_BOTH: begin
                    word.rbuf0_en = 1'b1;
                    word.rbuf1_en = 1'b1;
                end
                ST_READ_ONE: begin
                    word.rbuf0_en = 1'b1;
                    word.ra0_sel  = 1'b1;
                end
                ST_EXEC_RR: begin
                    word.alubuf_en = 1'b1;
                    word.alu_op    = alu_code;
                end
                ST_EXEC_IMM: begin
                    word.alubuf_en = 1'b1;
                    word.ra0_sel   = 1'b1;
                    word.b_sel     = B_IMM;
                    word.alu_op    = alu_code;
                end
                ST_WRITE_BACK: begin
                    word.reg_we = 1'b1;
                    word.wd_sel = WD_ALU;
                end
                ST_COPY_REG: begin
                    word.reg_we = 1'b1;
                    word.wd_sel = WD_REG;
                end
                ST_COPY_IMM: begin
                    word.reg_we = 1'b1;
                    word.wd_sel = WD_IMM;
                end
                ST_JUMP: begin
                    word.pc_we  = 1'b1;
                    word.pc_sel = 1'b1;
                end
                ST_JUMP_TRUE: begin
                    word.pc_we  = 1'b1;
                    word.pc_sel = rbit;
                end
                ST_JUMP_FALSE: begin
                    word.pc_we  = 1'b1;
                    word.pc_sel = ~rbit;
                end
                ST_PC_INC: begin
                    word.alubuf_en = 1'b1;
                    word.a_sel     = A_PC;
                    word.b_sel     = B_FOUR;
                    word.alu_op    = ALU_ADD;
                end
                ST_PC_STORE: begin
                    word.pc_we  = 1'b1;
                    word.pc_sel = 1'b0;
                end
                default: word = '0;
            endcase
        end
    end

endmodule

// File: rtl/proc_ctrl_fsm.sv
`timescale 1ns/1ps
module proc_ctrl_fsm
    import pctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [7:0]      opcode_i,
    input  logic            rbuf0_lsb_i,
    output logic [28:0]     ctl_word_o,
    output logic [3:0]      state_o
);

    state_t           state_q;
    state_t           state_d;
    opclass_t         cls;
    logic [ALU_W-1:0] alu_code;
    ctl_word_t        word;

    pctl_opdec #(.OPW(OP_W)) u_opdec (
        .opcode   (opcode_i),
        .cls      (cls),
        .alu_code (alu_code)
    );

    pctl_next_state u_next (
        .cur  (state_q),
        .cls  (cls),
        .rbit (rbuf0_lsb_i),
        .nxt  (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    pctl_word_gen u_word (
        .cur      (state_q),
        .alu_code (alu_code),
        .rbit     (rbuf0_lsb_i),
        .quiet    (rst),
        .word     (word)
    );

    always_comb begin
        ctl_word_o = word;
        state_o    = state_q;
    end

endmodule

// File: rtl/proc_ctrl_fsm_chk.sv
`timescale 1ns/1ps
module proc_ctrl_fsm_chk
    import pctl_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [7:0]  opcode_i,
    input logic        rbuf0_lsb_i,
    input logic [28:0] ctl_word_o,
    input logic [3:0]  state_o
);

    function automatic logic is_known(input logic [7:0] op);
        return (op <= 8'h0A && op != 8'h02) || op == OPC_ADDI || op == OPC_SUBI ||
               op == OPC_COPI || op == OPC_JUMP || op == OPC_TJMP || op == OPC_FJMP;
    endfunction

    p_reset_quiet_r1: assert property (@(posedge clk) rst |-> ctl_word_o == '0);

    p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_FETCH |=> state_o == ST_DECODE);

    p_store_return_r5: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_PC_STORE |=> state_o == ST_FETCH);

    p_wb_to_inc_r5: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_WRITE_BACK |=> state_o == ST_PC_INC);

    p_one_commit_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_word_o[28], ctl_word_o[27], ctl_word_o[24]}));

    p_jump_return_r8: assert property (@(posedge clk) disable iff (rst)
        state_o == ST_JUMP |=> state_o == ST_FETCH);

    p_true_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_JUMP_TRUE && rbuf0_lsb_i) |=> state_o == ST_FETCH);

    p_false_taken_r10: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_JUMP_FALSE && !rbuf0_lsb_i) |=> state_o == ST_FETCH);

    p_unknown_skip_r11: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DECODE && !is_known(opcode_i)) |=> state_o == ST_PC_INC);

endmodule

bind proc_ctrl_fsm proc_ctrl_fsm_chk i_chk (.*);

// File: tb/test_proc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_proc_ctrl_fsm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode_i = 8'h00;
    logic        rbuf0_lsb_i = 1'b0;
    logic [28:0] ctl_word_o;
    logic [3:0]  state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [3:0]  st;
        logic [28:0] cw;
        string       tag;
    } exp_t;

    exp_t q[$];

    localparam logic [28:0] W_FETCH = 29'h0800000;
    localparam logic [28:0] W_RD2   = 29'h0300000;
    localparam logic [28:0] W_RD1   = 29'h0210000;
    localparam logic [28:0] W_EXEC  = 29'h2000000;
    localparam logic [28:0] W_IMM   = 29'h2010100;
    localparam logic [28:0] W_WB    = 29'h8001000;
    localparam logic [28:0] W_COPY  = 29'h8002000;
    localparam logic [28:0] W_COPI  = 29'h8003000;
    localparam logic [28:0] W_JUMP  = 29'h1080000;
    localparam logic [28:0] W_CJ    = 29'h1000000;
    localparam logic [28:0] W_BIT19 = 29'h0080000;
    localparam logic [28:0] W_INC   = 29'h2000A00;
    localparam logic [28:0] W_STORE = 29'h1000000;

    always #2 clk = ~clk;

    proc_ctrl_fsm i_proc_ctrl_fsm (
        .clk         (clk),
        .rst         (rst),
        .opcode_i    (opcode_i),
        .rbuf0_lsb_i (rbuf0_lsb_i),
        .ctl_word_o  (ctl_word_o),
        .state_o     (state_o)
    );

    task automatic check(input string tag, input logic [3:0] est, input logic [28:0] ecw);
        checks++;
        if (state_o !== est || ctl_word_o !== ecw) begin
            fails++;
            $display("FAIL %s: state=%0d word=%07h expected state=%0d word=%07h",
                     tag, state_o, ctl_word_o, est, ecw);
        end
    endtask

    // Monitor: one expected item per cycle, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e.st, e.cw);
        end
    end

    task automatic push(input logic [3:0] st, input logic [28:0] cw, input string tag);
        exp_t e;
        e.st = st; e.cw = cw; e.tag = tag;
        q.push_back(e);
    endtask

    function automatic int alu_of(input logic [7:0] op);
        case (op)
            8'h00, 8'hFF: return 0;
            8'h01, 8'hFE: return 1;
            8'h03: return 3;
            8'h04: return 4;
            8'h05: return 5;
            8'h06: return 6;
            8'h07: return 7;
            8'h08: return 8;
            8'h09: return 9;
            default: return 0;
        endcase
    endfunction

    task automatic push_tail(input string tag);
        push(4'd12, W_INC, tag);
        push(4'd13, W_STORE, tag);
    endtask

    // Driver: entered at a rising edge + 1 ns with the design in FETCH.
    task automatic run(input logic [7:0] op, input logic b);
        logic [28:0] code;
        opcode_i    = op;
        rbuf0_lsb_i = b;
        code = 29'(alu_of(op));
        push(4'd0, W_FETCH, "R2 fetch");
        push(4'd1, 29'h0, "R2 decode");
        if (op <= 8'h09 && op != 8'h02) begin
            push(4'd2, W_RD2, "R3 read both");
            push(4'd4, W_EXEC | code, "R4 exec");
            push(4'd6, W_WB, "R5 write back");
            push_tail("R5 pc update");
        end else if (op == 8'hFF || op == 8'hFE) begin
            push(4'd3, W_RD1, "R6 read one");
            push(4'd5, W_IMM | code, "R6 exec imm");
            push(4'd6, W_WB, "R6 write back");
            push_tail("R6 pc update");
        end else if (op == 8'h0A) begin
            push(4'd3, W_RD1, "R7 read one");
            push(4'd7, W_COPY, "R7 copy");
            push_tail("R7 pc update");
        end else if (op == 8'hFD) begin
            push(4'd8, W_COPI, "R7 copy imm");
            push_tail("R7 pc update");
        end else if (op == 8'hE0) begin
            push(4'd9, W_JUMP, "R8 jump");
        end else if (op == 8'hFC) begin
            push(4'd3, W_RD1, "R9 read one");
            push(4'd10, W_CJ | (b ? W_BIT19 : 29'h0), "R9 jump true");
            if (!b) push_tail("R9 not taken");
        end else if (op == 8'hFB) begin
            push(4'd3, W_RD1, "R10 read one");
            push(4'd11, W_CJ | (b ? 29'h0 : W_BIT19), "R10 jump false");
            if (b) push_tail("R10 not taken");
        end else begin
            push_tail("R11 unknown opcode");
        end
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 4'd0, 29'h0);
        @(posedge clk); #1;
        rst = 1'b0;

        for (int i = 0; i <= 9; i++) begin
            if (i != 2) run(8'(i), 1'b0);
        end
        run(8'hFF, 1'b0);
        run(8'hFE, 1'b1);
        run(8'h0A, 1'b0);
        run(8'hFD, 1'b0);
        run(8'hE0, 1'b1);
        run(8'hFC, 1'b1);
        run(8'hFC, 1'b0);
        run(8'hFB, 1'b0);
        run(8'hFB, 1'b1);
        run(8'h02, 1'b0);
        run(8'h0B, 1'b0);
        run(8'h80, 1'b1);

        // R12: reset in the middle of an instruction
        opcode_i = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst = 1'b1;
        #0.5;
        checks++;
        if (ctl_word_o !== 29'h0) begin
            fails++;
            $display("FAIL R12 word during reset: %07h expected 0000000", ctl_word_o);
        end
        @(posedge clk);
        @(negedge clk);
        check("R12 held in reset", 4'd0, 29'h0);
        @(posedge clk); #1;
        rst = 1'b0;
        run(8'h05, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule